// File: doc/BRIEF.md
# Four-Phase Handshake Stage Controller

This block sequences one stage of a bundled-data pipeline from a system clock. It faces an upstream channel (request in, acknowledge out), a downstream channel (request out, acknowledge in) and a local datapath. The datapath stands in as a programmable delay counter: the controller raises a start strobe, waits for the counter's completion, and only then offers the captured word downstream. Every wire returns to zero before the next transfer.

A stage holds one word. The word is latched on the clock edge where start rises and is passed through unchanged. Stages connect head to tail to form a FIFO. The upstream acknowledge waits for the downstream acknowledge, so a chain moves in interlocked steps. A sticky flag reports any input transition that breaks the handshake order.

Top module: `hs_stage`

## Requirements
- R1: While reset is held, and after it is released with no request present, in_ack, out_req, calc_start, calc_done and proto_err are all low.
- R2: From idle, calc_start rises on the first clock edge at which in_req is sampled high. in_data is captured into the stage on that same edge.
- R3: calc_done rises exactly dly_cfg+1 cycles after calc_start rises, using the dly_cfg value sampled on the edge where start rose. Changes to dly_cfg at any other time have no effect.
- R4: out_req rises one cycle after calc_done rises. While out_req is high, out_data equals the captured word and does not change.
- R5: in_ack rises one cycle after out_ack is first sampled high. in_ack falls one cycle after out_ack is first sampled low during return-to-zero.
- R6: Return to zero runs in this order. calc_start falls one cycle after in_req is sampled low. calc_done falls one cycle after calc_start falls. out_req falls one cycle after calc_done falls.
- R7: At the ports, a correct transfer shows exactly this cycle of twelve transitions: in_req, calc_start, calc_done, out_req, out_ack and in_ack rise in that order, then fall in that same order.
- R8: Changes on in_data after the capture edge do not reach out_data.
- R9: proto_err sets on any of four input events and then stays high until reset. The four events are: in_req falls while in_ack is low; in_req rises while in_ack is high; out_ack rises while out_req is low; out_ack falls while out_req is high.
- R10: Stages chained into a FIFO deliver every word unchanged and in the order it was offered.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous reset, active low |
| in_req | input | 1 | Upstream request (data valid) |
| in_ack | output | 1 | Upstream acknowledge |
| in_data | input | DATA_W | Upstream bundled data |
| out_req | output | 1 | Downstream request |
| out_ack | input | 1 | Downstream acknowledge |
| out_data | output | DATA_W | Captured word offered downstream |
| dly_cfg | input | CNT_W | Matched-delay length in cycles |
| calc_start | output | 1 | Datapath start strobe |
| calc_done | output | 1 | Datapath completion |
| proto_err | output | 1 | Sticky handshake-order violation |

## Verification
The bench builds three stages with DATA_W=8 and CNT_W=4. The 4-bit counter puts the whole delay range within reach, including the shortest setting (0) and the longest (15). The first stage receives random delays, and its first two transfers force those two extremes. The middle and last stages use fixed delays of 5 and 15. With 8-bit words, the corrupted copy of each word that the bench drives after capture is distinct from the word itself.

// File: rtl/hs_pkg.sv
// Shared types for the four-phase stage controller.
// Assumes: one waiting state per handshake step, eight states in total.
package hs_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,   // waiting for upstream request
        ST_CALC,   // datapath running, counting down
        ST_DONE,   // completion seen, raise downstream request
        ST_OREQ,   // waiting for downstream acknowledge
        ST_IACK,   // upstream acknowledged, waiting for request to drop
        ST_DROP,   // start dropped, lower completion
        ST_ODROP,  // lower downstream request
        ST_WACK0   // waiting for downstream acknowledge to drop
    } hs_state_t;

endpackage

// File: rtl/hs_delay.sv
// Matched-delay emulation for the stage datapath.
// Loading sets the counter to cfg and arms it. Each later cycle counts down.
// expired is high for the single cycle in which an armed counter reads zero.
// Assumes load arrives only while the counter is disarmed.
module hs_delay #(
    parameter int CNT_W = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic [CNT_W-1:0] cfg,
    output logic             expired
);

    localparam logic [CNT_W-1:0] ZERO = '0;

    logic [CNT_W-1:0] cnt;
    logic             run;

    // Load, count down, and disarm once zero is reached.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt <= ZERO;
            run <= 1'b0;
        end else if (load) begin
            cnt <= cfg;
            run <= 1'b1;
        end else if (run) begin
            if (cnt == ZERO) begin
                run <= 1'b0;
            end else begin
                cnt <= cnt - 1'b1;
            end
        end
    end

    // Completion flag seen by the sequencer.
    always_comb begin
        expired = run && (cnt == ZERO);
    end

    // A zero-length load must expire on the very next cycle; any other length must not.
    assert_zero_load_R3: assert property (@(posedge clk) disable iff (!rst_n)
        load |=> (expired == ($past(cfg) == ZERO)));

    // Once armed, the counter never rises until the next load.
    assert_count_down_R3: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(run) && run && !$past(load)) |-> (cnt < $past(cnt)));

endmodule

// File: rtl/hs_latch.sv
// Data register of the stage, bundled with the request.
// Takes in d when cap is high and otherwise holds its value.
// Assumes cap pulses once per transfer, at start.
module hs_latch #(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cap,
    input  logic [DATA_W-1:0] d,
    output logic [DATA_W-1:0] q
);

    // Capture on cap, hold otherwise.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            q <= '0;
        end else if (cap) begin
            q <= d;
        end
    end

    // Without a capture the stored word stays the same.
    assert_hold_word_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !cap |=> $stable(q));

endmodule

// File: rtl/hs_seq.sv
// Four-phase sequencer for one stage.
// Raises start, waits for datapath completion, requests downstream,
// then acknowledges upstream. Return to zero follows the same order.
// Assumes expired is a one-cycle pulse from a counter loaded by load.
module hs_seq
    import hs_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic in_req,
    input  logic out_ack,
    input  logic expired,
    output logic start,
    output logic done,
    output logic out_req,
    output logic in_ack,
    output logic load
);

    hs_state_t st;

    // Begin a transfer as soon as a request is seen while idle.
    always_comb begin
        load = (st == ST_IDLE) && in_req;
    end

    // Step through the handshake one event at a time.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st      <= ST_IDLE;
            start   <= 1'b0;
            done    <= 1'b0;
            out_req <= 1'b0;
            in_ack  <= 1'b0;
        end else begin
            case (st)
                ST_IDLE: begin
                    if (in_req) begin
                        start <= 1'b1;
                        st    <= ST_CALC;
                    end
                end
                ST_CALC: begin
                    if (expired) begin
                        done <= 1'b1;
                        st   <= ST_DONE;
                    end
                end
                ST_DONE: begin
                    out_req <= 1'b1;
                    st      <= ST_OREQ;
                end
                ST_OREQ: begin
                    if (out_ack) begin
                        in_ack <= 1'b1;
                        st     <= ST_IACK;
                    end
                end
                ST_IACK: begin
                    if (!in_req) begin
                        start <= 1'b0;
                        st    <= ST_DROP;
                    end
                end
                ST_DROP: begin
                    done <= 1'b0;
                    st   <= ST_ODROP;
                end
                ST_ODROP: begin
                    out_req <= 1'b0;
                    st      <= ST_WACK0;
                end
                ST_WACK0: begin
                    if (!out_ack) begin
                        in_ack <= 1'b0;
                        st     <= ST_IDLE;
                    end
                end
                default: st <= ST_IDLE;
            endcase
        end
    end

    assert_start_follows_req_R2: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(start) |-> $past(in_req));

    assert_oreq_follows_done_R4: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(out_req) |-> (done && $past(done)));

    assert_iack_follows_oack_R5: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(in_ack) |-> $past(out_ack));

    assert_done_trails_start_R6: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(start) |=> $fell(done));

    assert_iack_returns_last_R6: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(in_ack) |-> (!$past(out_ack) && !out_req && !done && !start));

endmodule

// File: rtl/hs_err_watch.sv
// Handshake-order watchdog for both channels of a stage.
// Compares each input's last sampled value with its current value
// and with the output that should have come before it.
// Sets a flag that stays high until reset.
// Assumes every input is synchronous to clk.
module hs_err_watch (
    input  logic clk,
    input  logic rst_n,
    input  logic in_req,
    input  logic in_ack,
    input  logic out_req,
    input  logic out_ack,
    output logic err
);

    logic req_q;
    logic ack_q;
    logic bad;

    // Flag transitions that arrive before their enabling output.
    always_comb begin
        bad = ( req_q && !in_req  && !in_ack)
            | (!req_q &&  in_req  &&  in_ack)
            | (!ack_q &&  out_ack && !out_req)
            | ( ack_q && !out_ack &&  out_req);
    end

    // Track previous input levels and hold the error.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            req_q <= 1'b0;
            ack_q <= 1'b0;
            err   <= 1'b0;
        end else begin
            req_q <= in_req;
            ack_q <= out_ack;
            if (bad) begin
                err <= 1'b1;
            end
        end
    end

    assert_err_sticky_R9: assert property (@(posedge clk) disable iff (!rst_n)
        $past(err) |-> err);

    assert_early_drop_flags_R9: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(in_req) && !in_req && !in_ack) |=> err);

endmodule

// File: rtl/hs_stage.sv
// One stage of a bundled-data four-phase pipeline.
// Assembles the sequencer, the matched-delay counter, the data register and
// the order watchdog. Several stages connect head to tail to make a FIFO.
// Assumes all channel inputs are synchronous to clk.
module hs_stage #(
    parameter int DATA_W = 8,
    parameter int CNT_W  = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_req,
    output logic              in_ack,
    input  logic [DATA_W-1:0] in_data,
    output logic              out_req,
    input  logic              out_ack,
    output logic [DATA_W-1:0] out_data,
    input  logic [CNT_W-1:0]  dly_cfg,
    output logic              calc_start,
    output logic              calc_done,
    output logic              proto_err
);

    logic load;
    logic expired;

    hs_seq u_seq (
        .clk     (clk),
        .rst_n   (rst_n),
        .in_req  (in_req),
        .out_ack (out_ack),
        .expired (expired),
        .start   (calc_start),
        .done    (calc_done),
        .out_req (out_req),
        .in_ack  (in_ack),
        .load    (load)
    );

    hs_delay #(.CNT_W(CNT_W)) u_delay (
        .clk     (clk),
        .rst_n   (rst_n),
        .load    (load),
        .cfg     (dly_cfg),
        .expired (expired)
    );

    hs_latch #(.DATA_W(DATA_W)) u_latch (
        .clk   (clk),
        .rst_n (rst_n),
        .cap   (load),
        .d     (in_data),
        .q     (out_data)
    );

    hs_err_watch u_watch (
        .clk     (clk),
        .rst_n   (rst_n),
        .in_req  (in_req),
        .in_ack  (in_ack),
        .out_req (out_req),
        .out_ack (out_ack),
        .err     (proto_err)
    );

    // The offered word does not move while the downstream request is up.
    assert_word_steady_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (out_req && $past(out_req)) |-> $stable(out_data));

endmodule

// File: tb/hs_stage_test.sv
`timescale 1ns/1ps
module hs_stage_test;

    localparam int DW      = 8;
    localparam int CW      = 4;
    localparam int N_ITEMS = 40;
    localparam int WDOG    = 100000;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    always #2 clk = ~clk;

    logic          p_req;
    logic [DW-1:0] p_data;
    logic [CW-1:0] p_cfg;
    logic          a0, r01, a01, r12, a12, r_out, c_ack;
    logic [DW-1:0] d01, d12, d_out;
    logic          s0, dn0, s1, dn1, s2, dn2;
    logic          err0, err1, err2;

    hs_stage #(.DATA_W(DW), .CNT_W(CW)) uut (
        .clk(clk), .rst_n(rst_n), .in_req(p_req), .in_ack(a0), .in_data(p_data),
        .out_req(r01), .out_ack(a01), .out_data(d01), .dly_cfg(p_cfg),
        .calc_start(s0), .calc_done(dn0), .proto_err(err0));

    hs_stage #(.DATA_W(DW), .CNT_W(CW)) u_mid (
        .clk(clk), .rst_n(rst_n), .in_req(r01), .in_ack(a01), .in_data(d01),
        .out_req(r12), .out_ack(a12), .out_data(d12), .dly_cfg(CW'(5)),
        .calc_start(s1), .calc_done(dn1), .proto_err(err1));

    hs_stage #(.DATA_W(DW), .CNT_W(CW)) u_last (
        .clk(clk), .rst_n(rst_n), .in_req(r12), .in_ack(a12), .in_data(d12),
        .out_req(r_out), .out_ack(c_ack), .out_data(d_out), .dly_cfg(CW'(15)),
        .calc_start(s2), .calc_done(dn2), .proto_err(err2));

    int n_chk = 0;
    int n_bad = 0;
    int cyc = 0;
    int rcv = 0;
    bit mon_en = 0;
    bit err_phase = 0;
    bit ended = 0;
    int exp_cfg = 0;
    logic [DW-1:0] last_sent = '0;
    logic [DW-1:0] sent_q[$];

    task automatic check(input bit ok, input string tag, input string what,
                         input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s %s: got %0d expected %0d", tag, what, act, exp);
        end
    endtask

    task automatic finish_run();
        if (!ended) begin
            ended = 1;
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    endtask

    // Reference model of the twelve-event cycle at the first stage, checked each clock.
    initial begin
        logic [5:0] prev_v, cur_v;
        int exp_idx, t_req, t_start, t_done, t_oack, t_startf, t_donef, t_oackf, lat_cfg;
        prev_v = '0; exp_idx = 0; t_req = 0; t_start = 0; t_done = 0; t_oack = 0;
        t_startf = 0; t_donef = 0; t_oackf = 0; lat_cfg = 0;
        forever begin
            @(posedge clk);
            #1;
            cyc++;
            cur_v = {a0, a01, r01, dn0, s0, p_req};
            if (!rst_n || !mon_en) begin
                exp_idx = 0;
            end else begin
                for (int k = 0; k < 6; k++) begin
                    int s;
                    s = (k == 0) ? 0 : (k == 1) ? 4 : (k == 2) ? 1 : (k == 3) ? 2 : (k == 4) ? 3 : 5;
                    if (cur_v[s] != prev_v[s]) begin
                        int got;
                        got = cur_v[s] ? s : s + 6;
                        check(got == exp_idx, "R7", "handshake event index", got, exp_idx);
                        exp_idx = (got + 1) % 12;
                        case (got)
                            0: t_req = cyc;
                            1: begin
                                check(cyc == t_req, "R2", "start rise cycle", cyc, t_req);
                                t_start = cyc;
                                lat_cfg = exp_cfg;
                            end
                            2: begin
                                check(cyc - t_start == lat_cfg + 1, "R3", "start-to-done cycles",
                                      cyc - t_start, lat_cfg + 1);
                                t_done = cyc;
                            end
                            3: begin
                                check(cyc - t_done == 1, "R4", "done-to-out_req cycles", cyc - t_done, 1);
                                check(d01 == last_sent, "R8", "stage output word",
                                      int'(d01), int'(last_sent));
                            end
                            4: t_oack = cyc;
                            5: check(cyc - t_oack == 1, "R5", "out_ack-to-in_ack rise", cyc - t_oack, 1);
                            7: t_startf = cyc;
                            8: begin
                                check(cyc - t_startf == 1, "R6", "start-to-done fall", cyc - t_startf, 1);
                                t_donef = cyc;
                            end
                            9: check(cyc - t_donef == 1, "R6", "done-to-out_req fall", cyc - t_donef, 1);
                            10: t_oackf = cyc;
                            11: check(cyc - t_oackf == 1, "R5", "out_ack-to-in_ack fall", cyc - t_oackf, 1);
                            default: ;
                        endcase
                    end
                end
            end
            prev_v = cur_v;
        end
    end

    // Consumer at the end of the chain: checks order and value, then handshakes.
    initial begin
        c_ack = 1'b0;
        forever begin
            @(negedge clk);
            if (rst_n && r_out && !err_phase && !c_ack) begin
                int expv;
                expv = (sent_q.size() > 0) ? int'(sent_q[0]) : -1;
                check(int'(d_out) == expv, "R10", "FIFO output word", int'(d_out), expv);
                if (sent_q.size() > 0) void'(sent_q.pop_front());
                rcv++;
                repeat ($urandom_range(0, 4)) @(negedge clk);
                c_ack = 1'b1;
                while (r_out) @(negedge clk);
                repeat ($urandom_range(0, 4)) @(negedge clk);
                c_ack = 1'b0;
            end
        end
    end

    // Watchdog: a hung run counts as a failure.
    initial begin
        forever begin
            @(negedge clk);
            if (cyc > WDOG) begin
                n_chk++;
                n_bad++;
                $display("FAIL R10 watchdog: ran %0d cycles expected below %0d", cyc, WDOG);
                finish_run();
            end
        end
    end

    // Producer and directed sequences.
    initial begin
        p_req = 1'b0;
        p_data = '0;
        p_cfg = '0;
        rst_n = 1'b0;
        repeat (4) @(negedge clk);
        check({a0, r01, s0, dn0, err0, r_out, err2} == 7'b0, "R1", "outputs in reset",
              int'({a0, r01, s0, dn0, err0, r_out, err2}), 0);
        rst_n = 1'b1;
        mon_en = 1;
        repeat (3) @(negedge clk);
        check({a0, r01, s0, dn0, err0} == 5'b0, "R1", "idle without request",
              int'({a0, r01, s0, dn0, err0}), 0);

        for (int i = 0; i < N_ITEMS; i++) begin
            logic [DW-1:0] val;
            logic [CW-1:0] cfgv;
            repeat ($urandom_range(0, 3)) @(negedge clk);
            val  = DW'($urandom);
            cfgv = (i == 0) ? CW'(0) : (i == 1) ? CW'(15) : CW'($urandom_range(0, 15));
            exp_cfg = int'(cfgv);
            last_sent = val;
            sent_q.push_back(val);
            p_data = val;
            p_cfg  = cfgv;
            p_req  = 1'b1;
            @(negedge clk);
            p_data = ~val;
            p_cfg  = ~cfgv;
            while (!a0) @(negedge clk);
            repeat ($urandom_range(0, 3)) @(negedge clk);
            p_req = 1'b0;
            while (a0) @(negedge clk);
        end
        while (sent_q.size() != 0) @(negedge clk);
        repeat (10) @(negedge clk);
        check(rcv == N_ITEMS, "R10", "words delivered", rcv, N_ITEMS);
        check({err0, err1, err2} == 3'b0, "R9", "no error on legal traffic",
              int'({err0, err1, err2}), 0);

        // Request dropped before acknowledge.
        err_phase = 1;
        mon_en = 0;
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        c_ack = 1'b0;
        rst_n = 1'b1;
        @(negedge clk);
        check(err0 == 1'b0, "R9", "flag clear after reset", int'(err0), 0);
        p_cfg = CW'(3);
        p_req = 1'b1;
        @(negedge clk);
        p_req = 1'b0;
        @(negedge clk);
        check(err0 == 1'b1, "R9", "early request drop flagged", int'(err0), 1);
        repeat (20) @(negedge clk);
        check(err0 == 1'b1, "R9", "flag sticky", int'(err0), 1);
        check(err2 == 1'b0, "R9", "last stage unaffected", int'(err2), 0);

        // Acknowledge without a request at the end of the chain.
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check(err0 == 1'b0, "R9", "reset clears flag", int'(err0), 0);
        c_ack = 1'b1;
        @(negedge clk);
        check(err2 == 1'b1, "R9", "spurious acknowledge flagged", int'(err2), 1);
        check(err0 == 1'b0, "R9", "first stage unaffected", int'(err0), 0);
        c_ack = 1'b0;
        repeat (4) @(negedge clk);
        check(err2 == 1'b1, "R9", "flag sticky after ack drop", int'(err2), 1);
        finish_run();
    end

endmodule